// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms memory addresses for a 16-bit processor that reaches a 1 MB space through segment registers. Each cycle it takes an addressing-mode code, the two base registers, the two index registers, a displacement, the instruction pointer and four segment registers. From these it forms a 16-bit effective offset, picks the segment that applies, and produces the 20-bit physical address. The physical address is the segment value moved four bit places up, plus the offset.

Eight modes are supported. Direct, register-indirect, based, indexed, base-plus-index and base-plus-index-plus-displacement are used for data operands. Two instruction-pointer-relative modes are used for branch targets: a short one with a signed byte, and a near one with a full 16-bit displacement. The segment defaults to the stack segment when the BP register takes part in the address, to the code segment for branch targets, and to the data segment otherwise. An override input can replace the default for data modes.

The logic is purely combinational. A parameter can add one output register stage after it, so that the adders and the segment add finish inside their own cycle.

Top module: `seg_ea_gen`

## Requirements
- R1: Mode 0 (direct) gives an offset equal to the displacement. When `disp_short`=1, the offset is bits 7:0 of the displacement, sign-extended, and bits 15:8 have no effect.
- R2: Mode 1 (register indirect) gives an offset equal to the register that `rind_sel` picks: 0=BX, 1=BP, 2=SI, 3=DI. The displacement has no effect.
- R3: Mode 2 (based) gives the base register plus the displacement, modulo 2^16. The base is BX when `base_sel`=0 and BP when `base_sel`=1.
- R4: Mode 3 (indexed) gives the index register plus the displacement, modulo 2^16. The index is SI when `index_sel`=0 and DI when `index_sel`=1.
- R5: Mode 4 (base plus index) gives base plus index, modulo 2^16. The displacement has no effect.
- R6: Mode 5 gives base plus index plus displacement, modulo 2^16.
- R7: Mode 6 (short relative) gives the instruction pointer plus bits 7:0 of the displacement taken as a signed value in the range -128..+127. Bits 15:8 and `disp_short` have no effect.
- R8: Mode 7 (near relative) gives the instruction pointer plus the full 16-bit displacement. `disp_short` has no effect.
- R9: Segment codes are 0=ES, 1=CS, 2=SS, 3=DS. With no override, the segment is SS when BP is used (modes 2, 4 and 5 with `base_sel`=1, or mode 1 with `rind_sel`=1). It is CS for modes 6 and 7, and DS in every other case.
- R10: When `ovr_en`=1 in modes 0 to 5, `seg_code` equals `ovr_seg`. In modes 6 and 7 the override has no effect.
- R11: `phys_addr` equals the selected segment value times 16, plus the offset, modulo 2^20.
- R12: With `OUT_REG`=1, all outputs change one clock edge after their inputs.
- R13: While `rst_n` is low, the registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low reset |
| mode | input | 3 | Addressing mode 0..7 |
| base_sel | input | 1 | Base register: 0 BX, 1 BP |
| index_sel | input | 1 | Index register: 0 SI, 1 DI |
| rind_sel | input | 2 | Register for the indirect mode |
| disp | input | 16 | Displacement |
| disp_short | input | 1 | Take only the low byte of the displacement, sign-extended |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| ip | input | 16 | Instruction pointer |
| seg_es | input | 16 | Extra segment |
| seg_cs | input | 16 | Code segment |
| seg_ss | input | 16 | Stack segment |
| seg_ds | input | 16 | Data segment |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Override segment code |
| eff_off | output | 16 | Effective offset |
| seg_code | output | 2 | Segment used |
| phys_addr | output | 20 | Physical address |

## Verification
The bench sweeps every mode against every register select, short flag and override setting, using register values and displacements near the wrap points.

- A design that drops the 16-bit wrap would give a wrong `phys_addr` whenever the offset carries out.
- A design that zero-extends the short displacement would jump forward instead of backward for byte values of 0x80 and above.
- A design that applies the override to branch targets would move jumps out of the code segment.
- A design that keys SS off the mode alone, instead of off whether BP is used, would fail in the BX variants.

Every byte value is swept in short-relative mode around both ends of the offset range. A few vectors check that outputs hold until the clock edge.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;

   typedef enum logic [2:0] {
      AM_DIRECT        = 3'd0,
      AM_REG_IND       = 3'd1,
      AM_BASED         = 3'd2,
      AM_INDEXED       = 3'd3,
      AM_BASE_IDX      = 3'd4,
      AM_BASE_IDX_DISP = 3'd5,
      AM_REL_SHORT     = 3'd6,
      AM_REL_NEAR      = 3'd7
   } am_mode_e;

   typedef enum logic [1:0] {
      SEG_ES = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_DS = 2'd3
   } seg_code_e;

   function automatic logic is_branch_mode(input am_mode_e m);
      return (m == AM_REL_SHORT) || (m == AM_REL_NEAR);
   endfunction

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
   parameter int OFF_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic [OFF_W-1:0] disp_raw,
   input  logic             short_en,
   output logic [OFF_W-1:0] disp_data,
   output logic [OFF_W-1:0] disp_rel
);
   localparam int EXT_W = OFF_W - SHORT_W;

   logic [OFF_W-1:0] short_ext;

   generate
      if (EXT_W > 0) begin : g_ext
         assign short_ext = {{EXT_W{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
      end else begin : g_same
         assign short_ext = disp_raw;
      end
   endgenerate

   assign disp_data = short_en ? short_ext : disp_raw;
   assign disp_rel  = short_ext;

endmodule

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
   import seg_ea_pkg::*;
#(
   parameter int OFF_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  am_mode_e         mode,
   input  logic             base_sel,
   input  logic             index_sel,
   input  logic [1:0]       rind_sel,
   input  logic [OFF_W-1:0] reg_bx,
   input  logic [OFF_W-1:0] reg_bp,
   input  logic [OFF_W-1:0] reg_si,
   input  logic [OFF_W-1:0] reg_di,
   input  logic [OFF_W-1:0] ip,
   input  logic [OFF_W-1:0] disp_raw,
   input  logic             disp_short,
   input  logic [OFF_W-1:0] disp_data,
   input  logic [OFF_W-1:0] disp_rel,
   output logic [OFF_W-1:0] off
);
   logic [OFF_W-1:0] gp_regs [4];
   logic [OFF_W-1:0] base_val, idx_val, rind_val;
   logic [OFF_W-1:0] op_a, op_b, op_c;
   logic [OFF_W-1:0] rel_diff;

   assign gp_regs[0] = reg_bx;
   assign gp_regs[1] = reg_bp;
   assign gp_regs[2] = reg_si;
   assign gp_regs[3] = reg_di;

   assign base_val = base_sel  ? reg_bp : reg_bx;
   assign idx_val  = index_sel ? reg_di : reg_si;
   assign rind_val = gp_regs[rind_sel];

   always_comb begin
      op_a = '0;
      op_b = '0;
      op_c = '0;
      unique case (mode)
         AM_DIRECT:        op_c = disp_data;
         AM_REG_IND:       op_a = rind_val;
         AM_BASED:         begin op_a = base_val; op_c = disp_data; end
         AM_INDEXED:       begin op_b = idx_val;  op_c = disp_data; end
         AM_BASE_IDX:      begin op_a = base_val; op_b = idx_val;   end
         AM_BASE_IDX_DISP: begin op_a = base_val; op_b = idx_val; op_c = disp_data; end
         AM_REL_SHORT:     begin op_a = ip; op_c = disp_rel; end
         AM_REL_NEAR:      begin op_a = ip; op_c = disp_raw; end
         default:          op_a = '0;
      endcase
   end

   // three-input sum, wrapping at the offset width
   assign off = op_a + op_b + op_c;

   assign rel_diff = off - ip;

   assert_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AM_DIRECT && !disp_short) |-> (off == disp_raw));

   assert_rel_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AM_REL_SHORT) |->
         ((rel_diff[OFF_W-1:SHORT_W-1] == '0) || (rel_diff[OFF_W-1:SHORT_W-1] == '1)));

   assert_rind_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AM_REG_IND && rind_sel == 2'd3) |-> (off == reg_di));

endmodule

// File: rtl/ea_seg_sel.sv
module ea_seg_sel
   import seg_ea_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  am_mode_e         mode,
   input  logic             base_sel,
   input  logic [1:0]       rind_sel,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_seg,
   input  logic [SEG_W-1:0] seg_es,
   input  logic [SEG_W-1:0] seg_cs,
   input  logic [SEG_W-1:0] seg_ss,
   input  logic [SEG_W-1:0] seg_ds,
   output seg_code_e        code,
   output logic [SEG_W-1:0] seg_val
);
   logic [SEG_W-1:0] seg_bank [4];
   logic             bp_used;

   assign seg_bank[SEG_ES] = seg_es;
   assign seg_bank[SEG_CS] = seg_cs;
   assign seg_bank[SEG_SS] = seg_ss;
   assign seg_bank[SEG_DS] = seg_ds;

   always_comb begin
      unique case (mode)
         AM_BASED, AM_BASE_IDX, AM_BASE_IDX_DISP: bp_used = base_sel;
         AM_REG_IND:                              bp_used = (rind_sel == 2'd1);
         default:                                 bp_used = 1'b0;
      endcase
   end

   always_comb begin
      if (is_branch_mode(mode))
         code = SEG_CS;
      else if (ovr_en)
         code = seg_code_e'(ovr_seg);
      else if (bp_used)
         code = SEG_SS;
      else
         code = SEG_DS;
   end

   assign seg_val = seg_bank[code];

   assert_branch_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AM_REL_SHORT || mode == AM_REL_NEAR) |-> (code == SEG_CS));

   assert_bp_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && mode == AM_BASED && base_sel) |-> (code == SEG_SS));

   assert_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_en && mode < AM_REL_SHORT) |-> (code == ovr_seg));

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end

         assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (q == $past(d)));
      end else begin : g_comb
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
   import seg_ea_pkg::*;
#(
   parameter int OFF_W     = 16,
   parameter int SHORT_W   = 8,
   parameter int SEG_SHIFT = 4,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [2:0]                   mode,
   input  logic                         base_sel,
   input  logic                         index_sel,
   input  logic [1:0]                   rind_sel,
   input  logic [OFF_W-1:0]             disp,
   input  logic                         disp_short,
   input  logic [OFF_W-1:0]             reg_bx,
   input  logic [OFF_W-1:0]             reg_bp,
   input  logic [OFF_W-1:0]             reg_si,
   input  logic [OFF_W-1:0]             reg_di,
   input  logic [OFF_W-1:0]             ip,
   input  logic [OFF_W-1:0]             seg_es,
   input  logic [OFF_W-1:0]             seg_cs,
   input  logic [OFF_W-1:0]             seg_ss,
   input  logic [OFF_W-1:0]             seg_ds,
   input  logic                         ovr_en,
   input  logic [1:0]                   ovr_seg,
   output logic [OFF_W-1:0]             eff_off,
   output logic [1:0]                   seg_code,
   output logic [OFF_W+SEG_SHIFT-1:0]   phys_addr
);
   localparam int PA_W  = OFF_W + SEG_SHIFT;
   localparam int OUT_W = OFF_W + 2 + PA_W;

   generate
      if (SHORT_W < 2 || SHORT_W > OFF_W) begin : g_bad_short
         $error("seg_ea_gen: SHORT_W must lie in 2..OFF_W");
      end
      if (SEG_SHIFT < 1) begin : g_bad_shift
         $error("seg_ea_gen: SEG_SHIFT must be positive");
      end
   endgenerate

   am_mode_e         mode_e;
   logic [OFF_W-1:0] disp_data, disp_rel, off_c, seg_val;
   seg_code_e        code_c;
   logic [PA_W-1:0]  phys_c;
   logic [OUT_W-1:0] pack_d, pack_q;

   assign mode_e = am_mode_e'(mode);

   ea_disp_ext #(.OFF_W(OFF_W), .SHORT_W(SHORT_W)) u_disp (
      .disp_raw  (disp),
      .short_en  (disp_short),
      .disp_data (disp_data),
      .disp_rel  (disp_rel)
   );

   ea_offset_calc #(.OFF_W(OFF_W), .SHORT_W(SHORT_W)) u_off (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_e),
      .base_sel   (base_sel),
      .index_sel  (index_sel),
      .rind_sel   (rind_sel),
      .reg_bx     (reg_bx),
      .reg_bp     (reg_bp),
      .reg_si     (reg_si),
      .reg_di     (reg_di),
      .ip         (ip),
      .disp_raw   (disp),
      .disp_short (disp_short),
      .disp_data  (disp_data),
      .disp_rel   (disp_rel),
      .off        (off_c)
   );

   ea_seg_sel #(.SEG_W(OFF_W)) u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_e),
      .base_sel (base_sel),
      .rind_sel (rind_sel),
      .ovr_en   (ovr_en),
      .ovr_seg  (ovr_seg),
      .seg_es   (seg_es),
      .seg_cs   (seg_cs),
      .seg_ss   (seg_ss),
      .seg_ds   (seg_ds),
      .code     (code_c),
      .seg_val  (seg_val)
   );

   // shifted segment plus zero-extended offset, wrapping at PA_W bits
   assign phys_c = {seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off_c};

   assign pack_d = {off_c, code_c, phys_c};

   ea_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pack_d),
      .q     (pack_q)
   );

   assign eff_off   = pack_q[OUT_W-1 -: OFF_W];
   assign seg_code  = pack_q[PA_W+1 -: 2];
   assign phys_addr = pack_q[PA_W-1:0];

   assert_phys_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      phys_c[SEG_SHIFT-1:0] == off_c[SEG_SHIFT-1:0]);

endmodule

// File: tb/test_seg_ea_gen.sv
module test_seg_ea_gen;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  mode;
   logic        base_sel, index_sel, disp_short, ovr_en;
   logic [1:0]  rind_sel, ovr_seg;
   logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di, ip;
   logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
   logic [15:0] eff_off;
   logic [1:0]  seg_code;
   logic [19:0] phys_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [15:0] exp_off;
   logic [1:0]  exp_code;
   logic [19:0] exp_pa;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_ea_gen i_seg_ea_gen (
      .clk(clk), .rst_n(rst_n), .mode(mode), .base_sel(base_sel),
      .index_sel(index_sel), .rind_sel(rind_sel), .disp(disp),
      .disp_short(disp_short), .reg_bx(reg_bx), .reg_bp(reg_bp),
      .reg_si(reg_si), .reg_di(reg_di), .ip(ip), .seg_es(seg_es),
      .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds), .ovr_en(ovr_en),
      .ovr_seg(ovr_seg), .eff_off(eff_off), .seg_code(seg_code),
      .phys_addr(phys_addr)
   );

   task automatic check(input string req, input string what,
                        input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s mode=%0d actual=%h expected=%h", req, what, mode, act, exp);
      end
   endtask

   function automatic string mode_req(input logic [2:0] m);
      case (m)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R8";
      endcase
   endfunction

   // expected values from the requirement text
   task automatic compute_expected();
      logic [15:0] dd, dr, bv, iv, rv, sv;
      dr = {{8{disp[7]}}, disp[7:0]};
      dd = disp_short ? dr : disp;
      bv = base_sel ? reg_bp : reg_bx;
      iv = index_sel ? reg_di : reg_si;
      case (rind_sel)
         2'd0: rv = reg_bx;
         2'd1: rv = reg_bp;
         2'd2: rv = reg_si;
         default: rv = reg_di;
      endcase
      case (mode)
         3'd0: exp_off = dd;
         3'd1: exp_off = rv;
         3'd2: exp_off = bv + dd;
         3'd3: exp_off = iv + dd;
         3'd4: exp_off = bv + iv;
         3'd5: exp_off = bv + iv + dd;
         3'd6: exp_off = ip + dr;
         default: exp_off = ip + disp;
      endcase
      if (mode >= 3'd6)      exp_code = 2'd1;
      else if (ovr_en)       exp_code = ovr_seg;
      else if (((mode == 3'd2 || mode == 3'd4 || mode == 3'd5) && base_sel) ||
               (mode == 3'd1 && rind_sel == 2'd1))
                             exp_code = 2'd2;
      else                   exp_code = 2'd3;
      case (exp_code)
         2'd0: sv = seg_es;
         2'd1: sv = seg_cs;
         2'd2: sv = seg_ss;
         default: sv = seg_ds;
      endcase
      exp_pa = ((sv * 20'd16) + {4'h0, exp_off}) & 20'hFFFFF;
   endtask

   task automatic check_all();
      string sreq;
      sreq = (ovr_en && mode < 3'd6) ? "R10" : "R9";
      check(mode_req(mode), "offset", {4'h0, eff_off}, {4'h0, exp_off});
      check(sreq, "segment", {18'h0, seg_code}, {18'h0, exp_code});
      check("R11", "physical", phys_addr, exp_pa);
   endtask

   task automatic set_pattern(input int p);
      case (p)
         0: begin
            reg_bx = 16'h1234; reg_bp = 16'hFFF0; reg_si = 16'h0010; reg_di = 16'h8001;
            ip = 16'hFFF8; disp = 16'hFF85;
            seg_es = 16'h0000; seg_cs = 16'hF000; seg_ss = 16'hFFFF; seg_ds = 16'h1000;
         end
         1: begin
            reg_bx = 16'h0000; reg_bp = 16'h7FFF; reg_si = 16'hFFFF; reg_di = 16'h0002;
            ip = 16'h0005; disp = 16'h0080;
            seg_es = 16'hABCD; seg_cs = 16'h0001; seg_ss = 16'h8000; seg_ds = 16'hFFFE;
         end
         default: begin
            reg_bx = 16'hFFFF; reg_bp = 16'h0100; reg_si = 16'h4321; reg_di = 16'hFFFE;
            ip = 16'h8000; disp = 16'h127F;
            seg_es = 16'h0FFF; seg_cs = 16'h7654; seg_ss = 16'h0001; seg_ds = 16'hF0F0;
         end
      endcase
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stimulus
      logic [15:0] hold_off;
      rst_n = 1'b0;
      mode = 3'd2; base_sel = 1'b1; index_sel = 1'b0; rind_sel = 2'd0;
      disp_short = 1'b0; ovr_en = 1'b0; ovr_seg = 2'd0;
      set_pattern(0);
      repeat (3) @(negedge clk);
      // R13: outputs held at zero during reset
      check("R13", "reset offset", {4'h0, eff_off}, 20'h0);
      check("R13", "reset segment", {18'h0, seg_code}, 20'h0);
      check("R13", "reset physical", phys_addr, 20'h0);
      rst_n = 1'b1;

      for (int p = 0; p < 3; p++) begin
         set_pattern(p);
         for (int m = 0; m < 8; m++)
            for (int bs = 0; bs < 2; bs++)
               for (int is = 0; is < 2; is++)
                  for (int rs = 0; rs < 4; rs++)
                     for (int sh = 0; sh < 2; sh++)
                        for (int oe = 0; oe < 2; oe++)
                           for (int os = 0; os < 4; os++) begin
                              mode = 3'(m); base_sel = 1'(bs); index_sel = 1'(is);
                              rind_sel = 2'(rs); disp_short = 1'(sh);
                              ovr_en = 1'(oe); ovr_seg = 2'(os);
                              compute_expected();
                              @(negedge clk);
                              check_all();
                           end
      end

      // R7: full sweep of the signed byte near both ends of the offset range
      set_pattern(1);
      mode = 3'd6; ovr_en = 1'b1; ovr_seg = 2'd0;
      for (int q = 0; q < 2; q++) begin
         ip = (q == 0) ? 16'h0040 : 16'hFFC0;
         for (int b = 0; b < 256; b++) begin
            disp = {8'hA5, 8'(b)};
            disp_short = 1'(b & 1);
            compute_expected();
            @(negedge clk);
            check_all();
         end
      end

      // R12: new inputs must not reach the outputs before the clock edge
      for (int k = 0; k < 4; k++) begin
         hold_off = eff_off;
         mode = 3'd7; disp = 16'h0101 * 16'(k + 1); ip = 16'h2000;
         compute_expected();
         #1;
         check("R12", "held before edge", {4'h0, eff_off}, {4'h0, hold_off});
         @(negedge clk);
         check("R12", "updated after edge", {4'h0, eff_off}, {4'h0, exp_off});
      end

      // R13: reset in mid-run clears the outputs
      rst_n = 1'b0;
      #1;
      check("R13", "async reset", phys_addr, 20'h0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule